// File: doc/BRIEF.md
# Uncore Performance Counter Unit

This block watches event activity inside an on-chip interconnect node and collects it in a small set of wide counters that software reads through a single-cycle register port. Every counter carries an 8-bit event code. Some codes count occurrences: the counter adds one in each cycle where the matching event pulse is high. Other codes measure latency: the counter adds the current number of outstanding requests of the matching source in every cycle. Counting only happens while a global enable and the counter's own enable are both set.

A counter that wraps sets a sticky overflow status bit. Software clears that bit by writing a one to it. The interrupt line is the OR of every status bit whose mask bit is clear. Before software reads latency totals it can request a flush. The flush bit stays set until every enabled latency measurement has drained to zero outstanding requests, and then it clears itself.

The register port is 64 bits wide and has byte strobes. Control registers take their value from the low 32 bits of the write data. Counter registers take all 64 bits, and only the low `CNT_W` bits are stored.

Top module: `uncore_perf_counters`

## Requirements
- R1: After reset, all counters, counter enables, event codes, status bits, the global enable and the flush bit read 0. The mask register reads all ones (0xF with four counters), and `irq_o` is 0.
- R2: Address 0x1C04 always reads the `VERSION` parameter in bits 31:0. Writes to it have no effect.
- R3: Counter n is at 0x1E00 + 8·n and is read and written as 64 bits. Each byte strobe enables its own byte. Bits above `CNT_W` read 0.
- R4: The event code of counter n is in byte lane n mod 4 (bits 8·(n mod 4)+7 : 8·(n mod 4)) of the register at 0x1D00 + 4·(n/4). A write changes only the lanes whose strobes are set.
- R5: Bit 6 of the register at 0x408 is the global enable. While it is 0, no counter advances.
- R6: Bit n of the register at 0x1C00 enables counter n. A counter advances only when this bit and the global enable are both set.
- R7: Codes 0x00 to 0x0E select occurrence event `evt_pulse_i[code]`. The counter adds 1 in each enabled cycle where that pulse is high.
- R8: Codes 0x80 to 0x87 select latency source code−0x80. In each enabled cycle the counter adds that source's `OUT_W`-bit outstanding count, taken from bits (code−0x80)·OUT_W upward of `lat_outstanding_i`.
- R9: Any other code (for example 0x0F, 0x40, 0x88) counts nothing.
- R10: When counter n wraps past 2^CNT_W−1, it keeps the remainder and sets status bit n at 0x808.
- R11: At 0x800, mask bit n = 1 keeps status bit n away from `irq_o`, and mask bit n = 0 lets it through. `irq_o` is the OR of the status bits that are let through.
- R12: Writing to 0x80C clears each status bit whose write-data bit is 1 and leaves the others set. The address reads as 0.
- R13: Writing 1 to bit 0 of 0x400 sets the flush bit, which reads back there. The bit clears itself one cycle after every enabled counter with a latency code sees zero outstanding requests on its source. It is never set except by such a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe for this cycle |
| reg_addr_i | input | 16 | Register byte address |
| reg_wdata_i | input | 64 | Write data |
| reg_strb_i | input | 8 | Byte-enable strobes for write data |
| reg_rdata_o | output | 64 | Read data for `reg_addr_i` (combinational) |
| evt_pulse_i | input | NUM_OCC | Occurrence event pulses |
| lat_outstanding_i | input | NUM_LAT·OUT_W | Outstanding-request count per latency source |
| irq_o | output | 1 | Overflow interrupt |

## Verification
Several rules are checked by assertions in every cycle:
- counters hold while the global enable is off and no counter write occurs;
- status bits fall only after a clear write;
- a fully masked unit keeps its interrupt low;
- the flush bit rises only after a write to the flush control;
- the version address always returns the identifier.

Other behaviour can only be shown by the bench's scenarios:
- the arithmetic of occurrence and latency accumulation for each class of event code;
- byte-lane isolation in the event select register;
- the exact wrap remainder;
- the one-cycle self-clear of an already drained flush.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int ADDR_W = 16;

    localparam logic [ADDR_W-1:0] A_FLUSH  = 16'h0400;
    localparam logic [ADDR_W-1:0] A_GLOBAL = 16'h0408;
    localparam logic [ADDR_W-1:0] A_MASK   = 16'h0800;
    localparam logic [ADDR_W-1:0] A_STATUS = 16'h0808;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 16'h080C;
    localparam logic [ADDR_W-1:0] A_CNTEN  = 16'h1C00;
    localparam logic [ADDR_W-1:0] A_IDENT  = 16'h1C04;
    localparam logic [ADDR_W-1:0] A_EVSEL  = 16'h1D00;
    localparam logic [ADDR_W-1:0] A_COUNT  = 16'h1E00;

    localparam int GLB_EN_BIT   = 6;
    localparam int CODE_W       = 8;
    localparam int LANES        = 4;
    localparam int CNT_STRIDE   = 8;
    localparam int EVSEL_STRIDE = 4;
    localparam logic [CODE_W-1:0] LAT_CODE_BASE = 8'h80;

    // Expand byte strobes into a bit mask for 64-bit data.
    function automatic logic [63:0] strb_to_mask(input logic [7:0] strb);
        logic [63:0] m;
        for (int b = 0; b < 8; b++) begin
            m[b*8 +: 8] = {8{strb[b]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/upc_event_select.sv
module upc_event_select
    import pmu_pkg::*;
#(
    parameter int NUM_OCC = 15,
    parameter int NUM_LAT = 8,
    parameter int OUT_W   = 6
) (
    input  logic [CODE_W-1:0]        code_i,
    input  logic [NUM_OCC-1:0]       occ_i,
    input  logic [NUM_LAT*OUT_W-1:0] lat_i,
    output logic [OUT_W-1:0]         inc_o,
    output logic                     busy_o
);

    // Occurrence codes give 0/1 per cycle. Latency codes give the source's
    // outstanding count and report whether it is still non-zero.
    always_comb begin
        inc_o  = '0;
        busy_o = 1'b0;
        for (int i = 0; i < NUM_OCC; i++) begin
            if (code_i == CODE_W'(i)) begin
                inc_o = OUT_W'(occ_i[i]);
            end
        end
        for (int i = 0; i < NUM_LAT; i++) begin
            if (code_i == CODE_W'(LAT_CODE_BASE + i)) begin
                inc_o  = lat_i[i*OUT_W +: OUT_W];
                busy_o = |lat_i[i*OUT_W +: OUT_W];
            end
        end
    end

endmodule

// File: rtl/upc_counter_step.sv
module upc_counter_step #(
    parameter int CNT_W = 48,
    parameter int OUT_W = 6
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [OUT_W-1:0] inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] sum;

    assign sum    = {1'b0, cnt_i} + {{(SUM_W-OUT_W){1'b0}}, inc_i};
    assign cnt_o  = sum[CNT_W-1:0];
    assign wrap_o = sum[CNT_W];

endmodule

// File: rtl/uncore_perf_counters.sv
module uncore_perf_counters
    import pmu_pkg::*;
#(
    parameter int          NUM_CNT = 4,
    parameter int          CNT_W   = 48,
    parameter int          NUM_OCC = 15,
    parameter int          NUM_LAT = 8,
    parameter int          OUT_W   = 6,
    parameter logic [31:0] VERSION = 32'h0002_0100
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     reg_wr_i,
    input  logic [15:0]              reg_addr_i,
    input  logic [63:0]              reg_wdata_i,
    input  logic [7:0]               reg_strb_i,
    output logic [63:0]              reg_rdata_o,
    input  logic [NUM_OCC-1:0]       evt_pulse_i,
    input  logic [NUM_LAT*OUT_W-1:0] lat_outstanding_i,
    output logic                     irq_o
);

    localparam int LAT_W = NUM_LAT * OUT_W;

    typedef struct packed {
        logic                                glb_en;
        logic                                flush;
        logic [NUM_CNT-1:0]                  mask;
        logic [NUM_CNT-1:0]                  cnt_en;
        logic [NUM_CNT-1:0]                  status;
        logic [NUM_CNT-1:0][CODE_W-1:0]      code;
        logic [NUM_CNT-1:0][CNT_W-1:0]       cnt;
    } state_t;

    state_t st_d, st_q;

    logic [63:0]                     wmask;
    logic [NUM_CNT-1:0][OUT_W-1:0]   inc_raw;
    logic [NUM_CNT-1:0][OUT_W-1:0]   inc_gated;
    logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_next;
    logic [NUM_CNT-1:0]              cnt_wrap;
    logic [NUM_CNT-1:0]              lat_busy;
    logic [NUM_CNT-1:0]              cnt_active;
    logic [NUM_CNT-1:0]              cnt_wr_hit;
    logic                            drained;
    logic                            unused_bits;

    // Signals that the bound checker observes
    logic [NUM_CNT*CNT_W-1:0]        cnt_flat;
    logic [NUM_CNT-1:0]              status_vec;
    logic [NUM_CNT-1:0]              mask_vec;
    logic                            glb_en_vec;
    logic                            flush_vec;

    assign wmask       = strb_to_mask(reg_strb_i);
    assign unused_bits = ^{reg_wdata_i, wmask};

    // Event selection and accumulation, one slice per counter
    for (genvar n = 0; n < NUM_CNT; n++) begin : g_slice
        upc_event_select #(
            .NUM_OCC (NUM_OCC),
            .NUM_LAT (NUM_LAT),
            .OUT_W   (OUT_W)
        ) i_sel (
            .code_i  (st_q.code[n]),
            .occ_i   (evt_pulse_i),
            .lat_i   (lat_outstanding_i[LAT_W-1:0]),
            .inc_o   (inc_raw[n]),
            .busy_o  (lat_busy[n])
        );

        assign cnt_active[n] = st_q.glb_en & st_q.cnt_en[n];
        assign inc_gated[n]  = cnt_active[n] ? inc_raw[n] : '0;
        assign cnt_wr_hit[n] = reg_wr_i &&
                               (reg_addr_i == 16'(A_COUNT + CNT_STRIDE*n));

        upc_counter_step #(
            .CNT_W (CNT_W),
            .OUT_W (OUT_W)
        ) i_step (
            .cnt_i  (st_q.cnt[n]),
            .inc_i  (inc_gated[n]),
            .cnt_o  (cnt_next[n]),
            .wrap_o (cnt_wrap[n])
        );
    end

    // Flush may finish once no enabled latency measurement has requests pending
    assign drained = ~|(lat_busy & st_q.cnt_en);

    // Next-state computation
    always_comb begin
        st_d = st_q;

        if (reg_wr_i) begin
            if (reg_addr_i == A_GLOBAL && reg_strb_i[0]) begin
                st_d.glb_en = reg_wdata_i[GLB_EN_BIT];
            end
            if (reg_addr_i == A_MASK) begin
                st_d.mask = (st_q.mask & ~wmask[NUM_CNT-1:0]) |
                            (reg_wdata_i[NUM_CNT-1:0] & wmask[NUM_CNT-1:0]);
            end
            if (reg_addr_i == A_CNTEN) begin
                st_d.cnt_en = (st_q.cnt_en & ~wmask[NUM_CNT-1:0]) |
                              (reg_wdata_i[NUM_CNT-1:0] & wmask[NUM_CNT-1:0]);
            end
            if (reg_addr_i == A_CLEAR) begin
                st_d.status = st_q.status &
                              ~(reg_wdata_i[NUM_CNT-1:0] & wmask[NUM_CNT-1:0]);
            end
        end

        for (int n = 0; n < NUM_CNT; n++) begin
            if (reg_wr_i &&
                reg_addr_i == 16'(A_EVSEL + EVSEL_STRIDE*(n/LANES)) &&
                reg_strb_i[n%LANES]) begin
                st_d.code[n] = reg_wdata_i[CODE_W*(n%LANES) +: CODE_W];
            end

            if (cnt_wr_hit[n]) begin
                st_d.cnt[n] = (st_q.cnt[n] & ~wmask[CNT_W-1:0]) |
                              (reg_wdata_i[CNT_W-1:0] & wmask[CNT_W-1:0]);
            end else begin
                st_d.cnt[n] = cnt_next[n];
                if (cnt_wrap[n]) begin
                    st_d.status[n] = 1'b1;
                end
            end
        end

        if (st_q.flush && drained) begin
            st_d.flush = 1'b0;
        end
        if (reg_wr_i && reg_addr_i == A_FLUSH && reg_strb_i[0] && reg_wdata_i[0]) begin
            st_d.flush = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // Read data multiplexer
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_FLUSH:  reg_rdata_o[0]              = st_q.flush;
            A_GLOBAL: reg_rdata_o[GLB_EN_BIT]     = st_q.glb_en;
            A_MASK:   reg_rdata_o[NUM_CNT-1:0]    = st_q.mask;
            A_STATUS: reg_rdata_o[NUM_CNT-1:0]    = st_q.status;
            A_CNTEN:  reg_rdata_o[NUM_CNT-1:0]    = st_q.cnt_en;
            A_IDENT:  reg_rdata_o[31:0]           = VERSION;
            default:  reg_rdata_o                 = '0;
        endcase
        for (int n = 0; n < NUM_CNT; n++) begin
            if (reg_addr_i == 16'(A_EVSEL + EVSEL_STRIDE*(n/LANES))) begin
                reg_rdata_o[CODE_W*(n%LANES) +: CODE_W] = st_q.code[n];
            end
            if (reg_addr_i == 16'(A_COUNT + CNT_STRIDE*n)) begin
                reg_rdata_o[CNT_W-1:0] = st_q.cnt[n];
            end
        end
    end

    assign irq_o = |(st_q.status & ~st_q.mask);

    assign cnt_flat   = st_q.cnt;
    assign status_vec = st_q.status;
    assign mask_vec   = st_q.mask;
    assign glb_en_vec = st_q.glb_en;
    assign flush_vec  = st_q.flush;

endmodule

// File: rtl/upc_checker.sv
module upc_checker
    import pmu_pkg::*;
#(
    parameter int          NUM_CNT = 4,
    parameter int          CNT_W   = 48,
    parameter logic [31:0] VERSION = 32'h0002_0100
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     reg_wr_i,
    input logic [15:0]              reg_addr_i,
    input logic [63:0]              reg_rdata_o,
    input logic                     irq_o,
    input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
    input logic [NUM_CNT-1:0]       status_vec,
    input logic [NUM_CNT-1:0]       mask_vec,
    input logic                     glb_en_vec,
    input logic                     flush_vec
);

    logic cnt_wr;
    logic clr_wr;
    logic flush_wr;

    assign cnt_wr   = reg_wr_i && (reg_addr_i >= A_COUNT) &&
                      (reg_addr_i < 16'(A_COUNT + CNT_STRIDE*NUM_CNT));
    assign clr_wr   = reg_wr_i && (reg_addr_i == A_CLEAR);
    assign flush_wr = reg_wr_i && (reg_addr_i == A_FLUSH);

    p_hold_when_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!glb_en_vec && !cnt_wr) |=> $stable(cnt_flat));

    p_status_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_wr |=> ((status_vec & $past(status_vec)) == $past(status_vec)));

    p_masked_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (&mask_vec) |-> !irq_o);

    p_flush_from_write_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flush_vec) |-> $past(flush_wr));

    p_ident_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i == A_IDENT) |-> (reg_rdata_o == 64'(VERSION)));

endmodule

bind uncore_perf_counters upc_checker #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .VERSION (VERSION)
) i_upc_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .cnt_flat    (cnt_flat),
    .status_vec  (status_vec),
    .mask_vec    (mask_vec),
    .glb_en_vec  (glb_en_vec),
    .flush_vec   (flush_vec)
);

// File: tb/test_uncore_perf_counters.sv
module test_uncore_perf_counters;

    localparam int          NUM_CNT = 4;
    localparam int          CNT_W   = 48;
    localparam int          NUM_OCC = 15;
    localparam int          NUM_LAT = 8;
    localparam int          OUT_W   = 6;
    localparam logic [31:0] VERSION = 32'h0002_0100;

    localparam logic [15:0] FLUSH  = 16'h0400;
    localparam logic [15:0] GLOBAL = 16'h0408;
    localparam logic [15:0] MASK   = 16'h0800;
    localparam logic [15:0] STATUS = 16'h0808;
    localparam logic [15:0] CLEAR  = 16'h080C;
    localparam logic [15:0] CNTEN  = 16'h1C00;
    localparam logic [15:0] IDENT  = 16'h1C04;
    localparam logic [15:0] EVSEL  = 16'h1D00;
    localparam logic [15:0] COUNT  = 16'h1E00;

    typedef struct packed {
        logic [7:0]  code;
        logic [14:0] occ;
        logic [5:0]  lat;
        logic [7:0]  ncyc;
        logic [15:0] expect_cnt;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 15'h0001, 6'd0, 8'd5, 16'd5},   // R7 lowest occurrence code
        '{8'h0E, 15'h4000, 6'd0, 8'd7, 16'd7},   // R7 highest occurrence code
        '{8'h05, 15'h7FDF, 6'd0, 8'd6, 16'd0},   // R7 only the selected pulse counts
        '{8'h80, 15'h0000, 6'd3, 8'd4, 16'd12},  // R8 first latency source
        '{8'h87, 15'h0000, 6'd5, 8'd3, 16'd15},  // R8 last latency source
        '{8'h0F, 15'h7FFF, 6'd9, 8'd4, 16'd0},   // R9 just past occurrence range
        '{8'h88, 15'h7FFF, 6'd9, 8'd4, 16'd0},   // R9 just past latency range
        '{8'h40, 15'h7FFF, 6'd9, 8'd4, 16'd0}    // R9 gap between ranges
    };

    logic                     clk;
    logic                     rst_n;
    logic                     reg_wr;
    logic [15:0]              reg_addr;
    logic [63:0]              reg_wdata;
    logic [7:0]               reg_strb;
    logic [63:0]              reg_rdata;
    logic [NUM_OCC-1:0]       evt_pulse;
    logic [NUM_LAT*OUT_W-1:0] lat_out;
    logic                     irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    uncore_perf_counters #(
        .NUM_CNT (NUM_CNT),
        .CNT_W   (CNT_W),
        .NUM_OCC (NUM_OCC),
        .NUM_LAT (NUM_LAT),
        .OUT_W   (OUT_W),
        .VERSION (VERSION)
    ) i_uncore_perf_counters (
        .clk_i             (clk),
        .rst_ni            (rst_n),
        .reg_wr_i          (reg_wr),
        .reg_addr_i        (reg_addr),
        .reg_wdata_i       (reg_wdata),
        .reg_strb_i        (reg_strb),
        .reg_rdata_o       (reg_rdata),
        .evt_pulse_i       (evt_pulse),
        .lat_outstanding_i (lat_out),
        .irq_o             (irq)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [63:0] d, input logic [7:0] s);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        reg_strb  = s;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_strb  = '0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_cycles(input logic [NUM_OCC-1:0] occ,
                                input logic [NUM_LAT*OUT_W-1:0] lat, input int n);
        @(negedge clk);
        evt_pulse = occ;
        lat_out   = lat;
        repeat (n) @(negedge clk);
        evt_pulse = '0;
        lat_out   = '0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [63:0] v;
        reg_wr    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        reg_strb  = '0;
        evt_pulse = '0;
        lat_out   = '0;
        rst_n     = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(MASK, v);   check("R1 mask", v, 64'hF);
        rd(STATUS, v); check("R1 status", v, 64'h0);
        rd(CNTEN, v);  check("R1 enables", v, 64'h0);
        rd(GLOBAL, v); check("R1 global", v, 64'h0);
        rd(FLUSH, v);  check("R1 flush", v, 64'h0);
        rd(EVSEL, v);  check("R1 codes", v, 64'h0);
        for (int n = 0; n < NUM_CNT; n++) begin
            rd(16'(COUNT + 8*n), v); check("R1 counter", v, 64'h0);
        end
        check("R1 irq", {63'b0, irq}, 64'h0);

        // R2 identifier
        rd(IDENT, v); check("R2 ident", v, 64'(VERSION));
        wr(IDENT, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
        rd(IDENT, v); check("R2 ident after write", v, 64'(VERSION));

        // R3 64-bit counter access
        wr(16'(COUNT + 16), 64'hFFFF_1234_5678_9ABC, 8'hFF);
        rd(16'(COUNT + 16), v); check("R3 full write", v, 64'h0000_1234_5678_9ABC);
        wr(16'(COUNT + 16), 64'h0000_0000_0000_0011, 8'h01);
        rd(16'(COUNT + 16), v); check("R3 byte strobe", v, 64'h0000_1234_5678_9A11);

        // R4 byte lanes of the event select register
        wr(EVSEL, 64'h1122_3344, 8'h0F);
        wr(EVSEL, 64'h0000_5500, 8'h02);
        rd(EVSEL, v); check("R4 lane 1 only", v, 64'h1122_5544);
        wr(EVSEL, 64'h0000_0000, 8'h0F);

        // Vector table: counter 0 with each event code class (R7 R8 R9)
        wr(GLOBAL, 64'h40, 8'h01);
        wr(CNTEN, 64'h1, 8'h01);
        for (int i = 0; i < NVEC; i++) begin
            wr(COUNT, 64'h0, 8'hFF);
            wr(EVSEL, {56'h0, VECS[i].code}, 8'h01);
            pulse_cycles(VECS[i].occ, {NUM_LAT{VECS[i].lat}}, int'(VECS[i].ncyc));
            rd(COUNT, v);
            check($sformatf("R7/R8/R9 code %h", VECS[i].code), v, 64'(VECS[i].expect_cnt));
        end

        // R6 per-counter enable
        wr(EVSEL, 64'h0, 8'h0F);
        wr(COUNT, 64'h0, 8'hFF);
        wr(16'(COUNT + 8), 64'h0, 8'hFF);
        pulse_cycles(15'h0001, '0, 4);
        rd(COUNT, v);           check("R6 enabled counter", v, 64'd4);
        rd(16'(COUNT + 8), v);  check("R6 disabled counter", v, 64'd0);

        // R5 global enable off
        wr(GLOBAL, 64'h0, 8'h01);
        wr(CNTEN, 64'h3, 8'h01);
        pulse_cycles(15'h0001, '0, 4);
        rd(COUNT, v);           check("R5 counter 0 holds", v, 64'd4);
        rd(16'(COUNT + 8), v);  check("R5 counter 1 holds", v, 64'd0);

        // R10 wrap and status
        wr(CNTEN, 64'h8, 8'h01);
        wr(16'(COUNT + 24), 64'h0000_FFFF_FFFF_FFFE, 8'hFF);
        wr(GLOBAL, 64'h40, 8'h01);
        pulse_cycles(15'h0001, '0, 3);
        rd(16'(COUNT + 24), v); check("R10 wrapped remainder", v, 64'd1);
        rd(STATUS, v);          check("R10 status bit 3", v, 64'h8);

        // R11 masking of the interrupt
        check("R11 irq masked", {63'b0, irq}, 64'h0);
        wr(MASK, 64'h7, 8'h01);
        #1;
        check("R11 irq unmasked", {63'b0, irq}, 64'h1);
        wr(MASK, 64'hF, 8'h01);
        #1;
        check("R11 irq masked again", {63'b0, irq}, 64'h0);

        // R12 write-one-to-clear
        wr(CLEAR, 64'h4, 8'h01);
        rd(STATUS, v); check("R12 other bit kept", v, 64'h8);
        rd(CLEAR, v);  check("R12 clear reads zero", v, 64'h0);
        wr(CLEAR, 64'h8, 8'h01);
        rd(STATUS, v); check("R12 bit cleared", v, 64'h0);

        // R13 flush waits for outstanding requests
        wr(EVSEL, 64'h0000_8100, 8'h02);
        wr(CNTEN, 64'h2, 8'h01);
        @(negedge clk);
        lat_out = {{(NUM_LAT-2)*OUT_W{1'b0}}, 6'd2, 6'd0};
        wr(FLUSH, 64'h1, 8'h01);
        repeat (4) @(negedge clk);
        rd(FLUSH, v); check("R13 flush pending", v, 64'h1);
        lat_out = '0;
        repeat (2) @(negedge clk);
        rd(FLUSH, v); check("R13 flush drained", v, 64'h0);

        // R13 flush with nothing outstanding clears after one cycle
        wr(FLUSH, 64'h1, 8'h01);
        rd(FLUSH, v); check("R13 flush set", v, 64'h1);
        @(negedge clk);
        rd(FLUSH, v); check("R13 flush self-clear", v, 64'h0);

        done = 1'b1;
        finish_run();
    end

endmodule